// File: doc/BRIEF.md
# Tag Memory with Resettable OTP Words

This block is a register-level model of the memory of a small contactless tag. The memory holds sixteen 32-bit blocks, and each region applies its own write rule. Blocks 0 to 4 are one-time-programmable Boolean words: a write can only clear bits, and a word that reaches zero accepts no more writes. Blocks 5 and 6 are counters that can only count down. Blocks 7 to 15 are user words, each of which can be locked. A lock register sits at block address 255, and a fixed 64-bit identifier is driven on its own output.

A command front end drives one write port and one read port, each addressed by an 8-bit block number. A write is committed in one clock edge and is followed by a single busy cycle. A refused write raises an error flag in that same busy cycle. A write to block 6 that is accepted and changes the counter's upper half arms a reload. The next write to any OTP word then first restores all five OTP words to all ones and stores the new data unmasked in the addressed word.

Top module: `tagmem`

## Requirements
- R1: After reset, blocks 0-4 read all ones, blocks 5 and 6 read the CNT_INIT parameter, blocks 7-15 read zero, the lock register reads zero, and busy and wr_err are low.
- R2: rd_data reflects rd_addr in the same cycle. Addresses 0-15 return the stored block. Address 255 returns the lock register, with lock bits at positions 15:7 and all other bits zero. Any other address returns all ones.
- R3: A write to blocks 0-4, when no reload is armed, stores the old value AND the written data.
- R4: An OTP word that holds zero is not changed by a write unless a reload is armed.
- R5: A write to block 5 or 6 is stored only when the data is strictly lower than the stored value. Otherwise the block is unchanged and wr_err is high in the following cycle.
- R6: An accepted block-6 write whose bits 31:16 differ from the stored bits 31:16 arms a reload. The next OTP write sets all five OTP words to all ones, stores the data unmasked in the addressed word, and disarms the reload. Rejected counter writes do not arm a reload.
- R7: A write to an unlocked block 7-15 replaces all 32 bits.
- R8: A write to address 255 ORs data bits 15:7 into the lock register, and lock bits never clear. Lock bit k blocks writes to block k: such a write leaves the block unchanged and raises wr_err.
- R9: Writes to addresses 16-254 change no block, no lock bit and no flag except busy.
- R10: busy is high for exactly the one cycle after a write is taken. A write presented while busy is high is ignored and raises no error.
- R11: uid always equals the UID_VAL parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 8 | Block number to write |
| wr_data | input | 32 | Data to write |
| rd_addr | input | 8 | Block number to read |
| rd_data | output | 32 | Read data (combinational) |
| busy | output | 1 | High in the cycle after a write is taken |
| wr_err | output | 1 | High in that cycle if the write was refused |
| uid | output | 64 | Fixed identifier |

## Verification
Read data is combinational, so the bench samples it at the falling edge of the same cycle in which rd_addr is driven. A write is driven after a rising edge and commits at the next rising edge. busy and wr_err belong to the cycle that follows that edge, and the bench checks them at the falling edge inside it. Read-back of the written block starts one cycle after that. Every expected item is queued in the exact cycle its result is due, so a result that arrives one cycle early or late is compared against the wrong entry and fails.

// File: rtl/tagmem.sv
module tagmem #(
  parameter logic [63:0] UID_VAL  = 64'h0123_4567_89AB_CDEF,
  parameter logic [31:0] CNT_INIT = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [7:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        busy,
  output logic        wr_err,
  output logic [63:0] uid
);
  localparam logic [7:0]  NBLK      = 8'd16;
  localparam logic [7:0]  OTP_N     = 8'd5;
  localparam logic [7:0]  USR_LO    = 8'd7;
  localparam logic [7:0]  RELOAD_BK = 8'd6;
  localparam logic [7:0]  LOCK_ADDR = 8'd255;
  localparam logic [15:0] USR_MASK  = 16'hFF80;

  logic [31:0] mem [16];
  logic [15:0] lock;
  logic        armed, busy_q, err_q;

  wire [3:0] wa     = wr_addr[3:0];
  wire       go     = wr_en & ~busy_q;
  wire       in_mem = wr_addr < NBLK;
  wire       is_otp = wr_addr < OTP_N;
  wire       is_cnt = (wr_addr == 8'd5) || (wr_addr == RELOAD_BK);
  wire       is_usr = in_mem && (wr_addr >= USR_LO);
  wire       cnt_ok = wr_data < mem[wa];
  wire       reload = go && (wr_addr == RELOAD_BK) && cnt_ok &&
                      (wr_data[31:16] != mem[wa][31:16]);
  wire       erase_go = go && is_otp && armed;
  wire       rej    = go && ((is_cnt && !cnt_ok) || (is_usr && lock[wa]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++)
        mem[i] <= (i < 5) ? 32'hFFFF_FFFF : ((i == 5 || i == 6) ? CNT_INIT : 32'h0);
      lock   <= '0;
      armed  <= 1'b0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= go;
      err_q  <= rej;
      if (erase_go) begin
        for (int i = 0; i < 5; i++) mem[i] <= 32'hFFFF_FFFF;
        mem[wa] <= wr_data;
        armed   <= 1'b0;
      end else if (go && is_otp) begin
        if (mem[wa] != 32'h0) mem[wa] <= mem[wa] & wr_data;
      end else if (go && is_cnt) begin
        if (cnt_ok) mem[wa] <= wr_data;
        if (reload) armed <= 1'b1;
      end else if (go && is_usr) begin
        if (!lock[wa]) mem[wa] <= wr_data;
      end else if (go && wr_addr == LOCK_ADDR) begin
        lock <= lock | (wr_data[15:0] & USR_MASK);
      end
    end
  end

  assign rd_data = (rd_addr < NBLK)       ? mem[rd_addr[3:0]] :
                   (rd_addr == LOCK_ADDR) ? {16'h0, lock}     : 32'hFFFF_FFFF;
  assign busy   = busy_q;
  assign wr_err = err_q;
  assign uid    = UID_VAL;

  genvar g;
  generate
    for (g = 0; g < 5; g++) begin : g_otp_chk
      AST_OTP_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(erase_go) |-> ((mem[g] & ~$past(mem[g])) == 32'h0)); // R3
      AST_OTP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(erase_go) && $past(mem[g]) == 32'h0) |-> (mem[g] == 32'h0)); // R4
    end
    for (g = 5; g < 7; g++) begin : g_cnt_chk
      AST_CNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mem[g] <= $past(mem[g]))); // R5
    end
  endgenerate

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock & $past(lock)) == $past(lock))); // R8
  AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy); // R10
  AST_ERR_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> busy); // R5
endmodule

// File: tb/tb_tagmem.sv
module tb_tagmem;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] UID = 64'h0123_4567_89AB_CDEF;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic busy, wr_err;
  logic [63:0] uid;
  int total = 0, bad = 0;

  typedef struct { bit is_flag; bit [31:0] exp; string req; } item_t;
  item_t q[$];

  tagmem dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
              .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
              .busy(busy), .wr_err(wr_err), .uid(uid));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_flag ? {30'h0, busy, wr_err} : rd_data;
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string r);
    rd_addr = a;
    q.push_back('{1'b0, e, r});
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit e, input string r);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    q.push_back('{1'b1, {30'h0, 1'b1, e}, r});
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    q.push_back('{1'b1, 32'h0, "R1 flags"});
    @(posedge clk); #1;
    rd(8'd0, 32'hFFFF_FFFF, "R1 otp");
    rd(8'd5, 32'hFFFF_FFFF, "R1 counter");
    rd(8'd7, 32'h0, "R1 user");
    rd(8'd255, 32'h0, "R1 lock");
    rd(8'd16, 32'hFFFF_FFFF, "R2 unimplemented read");
    total++;
    if (uid !== UID) begin bad++; $display("FAIL R11: actual=%h expected=%h", uid, UID); end

    wr(8'd0, 32'h0F0F_0F0F, 1'b0, "R3 flags");
    wr(8'd0, 32'hFFFF_0000, 1'b0, "R3 flags");
    rd(8'd0, 32'h0F0F_0000, "R3 and");
    wr(8'd1, 32'h0, 1'b0, "R4 flags");
    wr(8'd1, 32'hFFFF_FFFF, 1'b0, "R4 flags");
    rd(8'd1, 32'h0, "R4 frozen");

    wr(8'd5, 32'hFFFF_FFFF, 1'b1, "R5 equal rejected");
    rd(8'd5, 32'hFFFF_FFFF, "R5 unchanged");
    wr(8'd5, 32'h10, 1'b0, "R5 lower ok");
    wr(8'd5, 32'h20, 1'b1, "R5 higher rejected");
    rd(8'd5, 32'h10, "R5 value");

    wr(8'd6, 32'hFFFF_FF00, 1'b0, "R6 lower half only");
    wr(8'd3, 32'hFFFF_00FF, 1'b0, "R6 flags");
    rd(8'd3, 32'hFFFF_00FF, "R6 not armed");
    rd(8'd0, 32'h0F0F_0000, "R6 not armed");
    wr(8'd6, 32'h0000_1000, 1'b0, "R6 arm");
    wr(8'd2, 32'h1234_5678, 1'b0, "R6 erase write");
    rd(8'd0, 32'hFFFF_FFFF, "R6 erased 0");
    rd(8'd1, 32'hFFFF_FFFF, "R6 erased 1");
    rd(8'd2, 32'h1234_5678, "R6 target");
    rd(8'd3, 32'hFFFF_FFFF, "R6 erased 3");
    rd(8'd4, 32'hFFFF_FFFF, "R6 erased 4");
    wr(8'd2, 32'h0000_FFFF, 1'b0, "R6 flags");
    rd(8'd2, 32'h0000_5678, "R6 disarmed");
    wr(8'd0, 32'h0, 1'b0, "R6 flags");
    wr(8'd6, 32'h0100_0000, 1'b1, "R6 rejected no arm");
    wr(8'd3, 32'h0000_FFFF, 1'b0, "R6 flags");
    rd(8'd0, 32'h0, "R6 no erase");
    rd(8'd3, 32'h0000_FFFF, "R6 masked");
    rd(8'd6, 32'h0000_1000, "R5 block6");

    wr(8'd7, 32'hDEAD_BEEF, 1'b0, "R7 flags");
    rd(8'd7, 32'hDEAD_BEEF, "R7 write");
    wr(8'd7, 32'h1, 1'b0, "R7 flags");
    rd(8'd7, 32'h1, "R7 full replace");

    wr(8'd255, 32'h0000_0200, 1'b0, "R8 flags");
    rd(8'd255, 32'h0000_0200, "R8 lock");
    wr(8'd9, 32'hAABB_CCDD, 1'b1, "R8 locked");
    rd(8'd9, 32'h0, "R8 locked unchanged");
    wr(8'd255, 32'h0, 1'b0, "R8 flags");
    rd(8'd255, 32'h0000_0200, "R8 sticky");
    wr(8'd255, 32'h0000_0408, 1'b0, "R8 flags");
    rd(8'd255, 32'h0000_0600, "R8 mask");
    wr(8'd8, 32'hCAFE_F00D, 1'b0, "R8 unlocked ok");
    rd(8'd8, 32'hCAFE_F00D, "R8 unlocked");
    wr(8'd10, 32'h1, 1'b1, "R8 locked 10");

    wr(8'd23, 32'h0, 1'b0, "R9 flags");
    wr(8'd20, 32'h0, 1'b0, "R9 flags");
    wr(8'd254, 32'hFFFF_FFFF, 1'b0, "R9 flags");
    rd(8'd23, 32'hFFFF_FFFF, "R9 read");
    rd(8'd7, 32'h1, "R9 no alias 7");
    rd(8'd4, 32'hFFFF_FFFF, "R9 no alias 4");
    rd(8'd255, 32'h0000_0600, "R9 lock kept");

    wr_en = 1'b1; wr_addr = 8'd8; wr_data = 32'h1111_1111;
    @(posedge clk); #1;
    wr_data = 32'h2222_2222;
    q.push_back('{1'b1, 32'h2, "R10 busy"});
    @(posedge clk); #1;
    wr_en = 1'b0;
    q.push_back('{1'b1, 32'h0, "R10 single cycle"});
    @(posedge clk); #1;
    rd(8'd8, 32'h1111_1111, "R10 ignored while busy");

    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule